// File: doc/BRIEF.md
# Shared Interrupt Source Sensing Unit

This unit sits in front of an interrupt router and turns a bank of external, already-synchronous request lines into per-source pending state. Every source carries its own sense setup: active-high or active-low, level or edge sensitive, and an option that makes both edges count. A latched edge stays pending until software clears it. Software can also raise any source's pending state itself, which is how one processor signals another over an edge-configured line.

Software works through a narrow write/read port. Sense setup, mask set, mask clear and the combined clear/inject command are all written as a source index plus a few flag bits, so one write touches exactly one source. Reads return a size word, or a 32-bit slice of the pending bitmap or of the mask bitmap. The masked request vector `req_o` goes to the downstream router; choosing a processor and a vector happens elsewhere.

Top module: `shirq_sense`

## Requirements
- R1: After reset every source is level-sensitive, active-high and masked. `req_o` is zero, both mask words read zero, and each pending bit follows its input level.
- R2: A read at address 0x00 returns (NUM_SRC/8)-1 in bits [4:0] and zero in the bits above. NUM_SRC is a multiple of 8 and at most 256.
- R3: A write to address 0x00 sets up the source whose index is in bits [7:0]. Bit 8 selects active-low/falling, bit 9 selects edge sensing and bit 10 selects both edges. A level source is pending while its input is at the active level.
- R4: An edge source without the both-edges option latches pending on a rising edge when bit 8 is 0 and on a falling edge when bit 8 is 1. The latch holds after the input returns.
- R5: With the both-edges option, a rising edge and a falling edge each latch pending, whatever the polarity bit holds.
- R6: A write to address 0x01 sets the mask bit of the indexed source, and a write to 0x02 clears it. No other mask bit changes. `req_o` is pending AND mask. A masked edge source still latches, and it requests as soon as it is unmasked.
- R7: A write to address 0x03 with bit 31 clear removes the latched state of the indexed source. If an edge event on that source arrives in the same cycle, the source stays pending.
- R8: A write to address 0x03 with bit 31 set makes the indexed source pending. On a level source this holds while the input is inactive, until a clear through address 0x03.
- R9: A write whose index is NUM_SRC or more changes no setup, mask or pending state.
- R10: A read at 0x10+w returns pending bits 32w..32w+31, with bit b giving source 32w+b, whatever the mask holds. A read at 0x20+w returns the mask bits the same way. Word numbers past the last word read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | External request lines, synchronous to clk_i |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Write address (0x00 setup, 0x01 mask set, 0x02 mask clear, 0x03 clear/inject) |
| wr_data_i | input | 32 | Write data: index in [7:0], flags above |
| rd_addr_i | input | 6 | Read address |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i and state |
| req_o | output | NUM_SRC | Pending and unmasked request per source |

## Verification
The properties assume that no more than one command arrives per cycle and that `src_i` is already synchronous to the clock. With that assumption, a mask or clear/inject write is the only thing in a cycle that can move that source's mask bit or pending latch. The clear property also assumes that the line does not change in the cycle of the clear, and it checks this by comparing the input with its stored previous sample. The bench drives every input on the falling clock edge and issues at most one write per cycle. It changes a cleared line's input only in the one case that deliberately tests a clear and an edge arriving together, and no property covers that case.

// File: rtl/shirq_pkg.sv
package shirq_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 8;

    localparam int POL_BIT  = 8;
    localparam int TRIG_BIT = 9;
    localparam int DUAL_BIT = 10;
    localparam int INJ_BIT  = 31;

    typedef enum logic [1:0] {
        OP_SENSE = 2'd0,
        OP_MSET  = 2'd1,
        OP_MCLR  = 2'd2,
        OP_WEDGE = 2'd3
    } wr_op_e;

    typedef enum logic [1:0] {
        RG_CFG  = 2'd0,
        RG_PEND = 2'd1,
        RG_MASK = 2'd2,
        RG_NONE = 2'd3
    } rd_region_e;
endpackage

// File: rtl/shirq_wr_decode.sv
module shirq_wr_decode
    import shirq_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [NUM_SRC-1:0] cfg_we_o,
    output logic [NUM_SRC-1:0] mset_o,
    output logic [NUM_SRC-1:0] mclr_o,
    output logic [NUM_SRC-1:0] wclr_o,
    output logic [NUM_SRC-1:0] wset_o,
    output logic              cfg_pol_o,
    output logic              cfg_trig_o,
    output logic              cfg_dual_o
);
    logic [IDX_W-1:0]   idx;
    logic               in_rng;
    logic               cmd_ok;
    wr_op_e             op;
    logic [NUM_SRC-1:0] sel;
    logic               unused_data;

    assign idx    = wr_data_i[IDX_W-1:0];
    assign in_rng = ({1'b0, idx} < (IDX_W+1)'(NUM_SRC));
    assign op     = wr_op_e'(wr_addr_i[1:0]);
    assign cmd_ok = wr_en_i && (wr_addr_i[ADDR_W-1:2] == '0) && in_rng;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_sel
        assign sel[i] = (idx == IDX_W'(i));
    end

    assign cfg_we_o = sel & {NUM_SRC{cmd_ok && (op == OP_SENSE)}};
    assign mset_o   = sel & {NUM_SRC{cmd_ok && (op == OP_MSET)}};
    assign mclr_o   = sel & {NUM_SRC{cmd_ok && (op == OP_MCLR)}};
    assign wclr_o   = sel & {NUM_SRC{cmd_ok && (op == OP_WEDGE) && !wr_data_i[INJ_BIT]}};
    assign wset_o   = sel & {NUM_SRC{cmd_ok && (op == OP_WEDGE) &&  wr_data_i[INJ_BIT]}};

    assign cfg_pol_o   = wr_data_i[POL_BIT];
    assign cfg_trig_o  = wr_data_i[TRIG_BIT];
    assign cfg_dual_o  = wr_data_i[DUAL_BIT];
    assign unused_data = ^wr_data_i[INJ_BIT-1:DUAL_BIT+1];
endmodule

// File: rtl/shirq_edge_sense.sv
module shirq_edge_sense #(
    parameter int NUM_SRC = 64
) (
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] prev_i,
    input  logic [NUM_SRC-1:0] pol_i,
    input  logic [NUM_SRC-1:0] trig_i,
    input  logic [NUM_SRC-1:0] dual_i,
    input  logic [NUM_SRC-1:0] lat_i,
    output logic [NUM_SRC-1:0] evt_o,
    output logic [NUM_SRC-1:0] pend_o
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic rise, fall, hit;
        assign rise = src_i[i] & ~prev_i[i];
        assign fall = ~src_i[i] & prev_i[i];
        // both-edges option overrides polarity
        assign hit  = dual_i[i] ? (rise | fall) : (pol_i[i] ? fall : rise);
        assign evt_o[i]  = trig_i[i] & hit;
        assign pend_o[i] = lat_i[i] | (~trig_i[i] & (src_i[i] ^ pol_i[i]));
    end
endmodule

// File: rtl/shirq_rd_mux.sv
module shirq_rd_mux
    import shirq_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic [ADDR_W-1:0]  rd_addr_i,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic [DATA_W-1:0]  rd_data_o
);
    localparam int NWORDS  = (NUM_SRC + DATA_W - 1) / DATA_W;
    localparam int SIZE_CD = NUM_SRC / 8 - 1;

    rd_region_e               region;
    logic [3:0]               wsel;
    logic [NWORDS*DATA_W-1:0] pend_pad;
    logic [NWORDS*DATA_W-1:0] mask_pad;
    logic [DATA_W-1:0]        pend_word;
    logic [DATA_W-1:0]        mask_word;

    assign region = rd_region_e'(rd_addr_i[5:4]);
    assign wsel   = rd_addr_i[3:0];

    always_comb begin
        pend_pad = '0;
        mask_pad = '0;
        pend_pad[NUM_SRC-1:0] = pend_i;
        mask_pad[NUM_SRC-1:0] = mask_i;
        pend_word = '0;
        mask_word = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (int'(wsel) == w) begin
                pend_word = pend_pad[w*DATA_W +: DATA_W];
                mask_word = mask_pad[w*DATA_W +: DATA_W];
            end
        end
    end

    always_comb begin
        case (region)
            RG_CFG:  rd_data_o = (wsel == 4'd0) ? DATA_W'(5'(SIZE_CD)) : '0;
            RG_PEND: rd_data_o = pend_word;
            RG_MASK: rd_data_o = mask_word;
            default: rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/shirq_sense.sv
module shirq_sense
    import shirq_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic [NUM_SRC-1:0] req_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] pol;
        logic [NUM_SRC-1:0] trig;
        logic [NUM_SRC-1:0] dual;
        logic [NUM_SRC-1:0] mask;
        logic [NUM_SRC-1:0] lat;
        logic [NUM_SRC-1:0] prev;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SRC-1:0] cfg_we, mset, mclr, wclr, wset;
    logic               cfg_pol, cfg_trig, cfg_dual;
    logic [NUM_SRC-1:0] evt, pend;

    shirq_wr_decode #(.NUM_SRC(NUM_SRC)) u_dec (
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .cfg_we_o   (cfg_we),
        .mset_o     (mset),
        .mclr_o     (mclr),
        .wclr_o     (wclr),
        .wset_o     (wset),
        .cfg_pol_o  (cfg_pol),
        .cfg_trig_o (cfg_trig),
        .cfg_dual_o (cfg_dual)
    );

    shirq_edge_sense #(.NUM_SRC(NUM_SRC)) u_sense (
        .src_i  (src_i),
        .prev_i (st_q.prev),
        .pol_i  (st_q.pol),
        .trig_i (st_q.trig),
        .dual_i (st_q.dual),
        .lat_i  (st_q.lat),
        .evt_o  (evt),
        .pend_o (pend)
    );

    shirq_rd_mux #(.NUM_SRC(NUM_SRC)) u_rd (
        .rd_addr_i (rd_addr_i),
        .pend_i    (pend),
        .mask_i    (st_q.mask),
        .rd_data_o (rd_data_o)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pol  = (st_q.pol  & ~cfg_we) | ({NUM_SRC{cfg_pol}}  & cfg_we);
        st_d.trig = (st_q.trig & ~cfg_we) | ({NUM_SRC{cfg_trig}} & cfg_we);
        st_d.dual = (st_q.dual & ~cfg_we) | ({NUM_SRC{cfg_dual}} & cfg_we);
        st_d.mask = (st_q.mask | mset) & ~mclr;
        // a set from an edge or an inject wins over a clear in the same cycle
        st_d.lat  = (st_q.lat & ~wclr) | evt | wset;
        st_d.prev = src_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o = pend & st_q.mask;
endmodule

// File: rtl/shirq_sense_chk.sv
module shirq_sense_chk
    import shirq_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               wr_en_i,
    input logic [ADDR_W-1:0]  wr_addr_i,
    input logic [DATA_W-1:0]  wr_data_i,
    input logic [NUM_SRC-1:0] src_i,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_SRC-1:0] lat_q,
    input logic [NUM_SRC-1:0] prev_q,
    input logic [NUM_SRC-1:0] trig_q
);
    localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic          ok_idx;
    logic [IW-1:0] ix;
    logic          unused_bits;

    assign ok_idx      = (wr_data_i[IDX_W-1:0] < IDX_W'(NUM_SRC));
    assign ix          = wr_data_i[IW-1:0];
    assign unused_bits = ^wr_data_i[INJ_BIT-1:IDX_W];

    p_mask_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == 6'h01 && ok_idx) |=> mask_q[$past(ix)]);

    p_mask_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == 6'h02 && ok_idx) |=> !mask_q[$past(ix)]);

    p_inject_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == 6'h03 && wr_data_i[INJ_BIT] && ok_idx)
        |=> lat_q[$past(ix)]);

    p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == 6'h03 && !wr_data_i[INJ_BIT] && ok_idx
         && (src_i[ix] == prev_q[ix])) |=> !lat_q[$past(ix)]);

    p_out_of_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i[ADDR_W-1:2] == '0 && !ok_idx)
        |=> ($stable(mask_q) && $stable(trig_q)));
endmodule

bind shirq_sense shirq_sense_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .src_i     (src_i),
    .mask_q    (st_q.mask),
    .lat_q     (st_q.lat),
    .prev_q    (st_q.prev),
    .trig_q    (st_q.trig)
);

// File: tb/shirq_sense_bench.sv
module shirq_sense_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 64;

    typedef struct packed {
        logic        wr;
        logic [5:0]  waddr;
        logic [31:0] wdata;
        logic [63:0] src;
        logic [5:0]  raddr;
        logic [31:0] exp;
        logic [7:0]  req;
    } step_t;

    localparam int NSTEP = 26;
    localparam step_t TBL [NSTEP] = '{
        '{1'b0, 6'h00, 32'h0,          64'h0,                  6'h00, 32'h7,  8'd2},  // R2 size word
        '{1'b0, 6'h00, 32'h0,          64'h0000_0001_0000_0005, 6'h10, 32'h5,  8'd1},  // R1 level follows input
        '{1'b0, 6'h00, 32'h0,          64'h0000_0001_0000_0005, 6'h11, 32'h1,  8'd10}, // R10 word 1
        '{1'b0, 6'h00, 32'h0,          64'h0000_0001_0000_0005, 6'h20, 32'h0,  8'd1},  // R1 masked
        '{1'b1, 6'h00, 32'h102,        64'h0000_0001_0000_0005, 6'h10, 32'h1,  8'd3},  // R3 active-low
        '{1'b0, 6'h00, 32'h0,          64'h0000_0001_0000_0001, 6'h10, 32'h5,  8'd3},  // R3 low level pends
        '{1'b1, 6'h00, 32'h203,        64'h0000_0001_0000_0001, 6'h10, 32'h5,  8'd4},  // R4 set rising edge
        '{1'b0, 6'h00, 32'h0,          64'h0000_0001_0000_0009, 6'h10, 32'hD,  8'd4},  // R4 rise latches
        '{1'b0, 6'h00, 32'h0,          64'h0000_0001_0000_0001, 6'h10, 32'hD,  8'd4},  // R4 held
        '{1'b1, 6'h03, 32'h3,          64'h0000_0001_0000_0001, 6'h10, 32'h5,  8'd7},  // R7 clear
        '{1'b1, 6'h00, 32'h304,        64'h0000_0001_0000_0011, 6'h10, 32'h5,  8'd4},  // R4 falling setup
        '{1'b0, 6'h00, 32'h0,          64'h0000_0001_0000_0001, 6'h10, 32'h15, 8'd4},  // R4 fall latches
        '{1'b1, 6'h00, 32'h705,        64'h0000_0001_0000_0001, 6'h10, 32'h15, 8'd5},  // R5 dual setup
        '{1'b0, 6'h00, 32'h0,          64'h0000_0001_0000_0021, 6'h10, 32'h35, 8'd5},  // R5 rise
        '{1'b1, 6'h03, 32'h5,          64'h0000_0001_0000_0021, 6'h10, 32'h15, 8'd7},  // R7 clear
        '{1'b0, 6'h00, 32'h0,          64'h0000_0001_0000_0001, 6'h10, 32'h35, 8'd5},  // R5 fall
        '{1'b1, 6'h01, 32'h5,          64'h0000_0001_0000_0001, 6'h20, 32'h20, 8'd6},  // R6 mask set
        '{1'b1, 6'h01, 32'h23,         64'h0000_0001_0000_0001, 6'h21, 32'h8,  8'd6},  // R6 word 1 mask
        '{1'b1, 6'h01, 32'h40,         64'h0000_0001_0000_0001, 6'h21, 32'h8,  8'd9},  // R9 index 64
        '{1'b0, 6'h00, 32'h0,          64'h0000_0001_0000_0001, 6'h12, 32'h0,  8'd10}, // R10 past end
        '{1'b1, 6'h03, 32'h8000_0028,  64'h0000_0001_0000_0001, 6'h11, 32'h101, 8'd8}, // R8 inject level
        '{1'b1, 6'h03, 32'h28,         64'h0000_0001_0000_0001, 6'h11, 32'h1,  8'd8},  // R8 cleared
        '{1'b1, 6'h03, 32'h8000_0064,  64'h0000_0001_0000_0001, 6'h11, 32'h1,  8'd9},  // R9 inject index 100
        '{1'b1, 6'h02, 32'h5,          64'h0000_0001_0000_0001, 6'h20, 32'h0,  8'd6},  // R6 mask clear
        '{1'b1, 6'h03, 32'h3,          64'h0000_0001_0000_0009, 6'h10, 32'h3D, 8'd7},  // R7 edge beats clear
        '{1'b1, 6'h00, 32'h240,        64'h0000_0001_0000_0009, 6'h10, 32'h3D, 8'd9}   // R9 setup index 64
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src = '0;
    logic            wr_en = 1'b0;
    logic [5:0]      wr_addr = '0;
    logic [31:0]     wr_data = '0;
    logic [5:0]      rd_addr = '0;
    logic [31:0]     rd_data;
    logic [NSRC-1:0] req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shirq_sense #(.NUM_SRC(NSRC)) u_shirq_sense (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .src_i     (src),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .req_o     (req)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic w, input logic [5:0] wa, input logic [31:0] wd,
                         input logic [63:0] s, input logic [5:0] ra);
        @(negedge clk);
        src = s; wr_en = w; wr_addr = wa; wr_data = wd; rd_addr = ra;
        @(posedge clk);
        #1;
    endtask

    task automatic read_now(input logic [5:0] ra);
        @(negedge clk);
        wr_en = 1'b0;
        rd_addr = ra;
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports
        read_now(6'h20);
        check("R1 mask word0 after reset", 64'(rd_data), 64'h0);
        check("R1 req after reset", req, 64'h0);

        for (int k = 0; k < NSTEP; k++) begin
            cycle(TBL[k].wr, TBL[k].waddr, TBL[k].wdata, TBL[k].src, TBL[k].raddr);
            check($sformatf("R%0d table step %0d", TBL[k].req, k), 64'(rd_data), 64'(TBL[k].exp));
        end

        // R6: unmask a level source that is pending
        cycle(1'b1, 6'h01, 32'h0, 64'h0000_0001_0000_0009, 6'h10);
        check("R6 req after unmask bit0", req, 64'h1);
        // R6: edge latched while masked requests once unmasked
        cycle(1'b1, 6'h01, 32'h4, 64'h0000_0001_0000_0009, 6'h10);
        check("R6 masked latch now requests", req, 64'h11);
        cycle(1'b1, 6'h01, 32'h3, 64'h0000_0001_0000_0009, 6'h10);
        check("R6 req with bit3", req, 64'h19);
        // R9: out-of-range mask clear leaves masks alone
        cycle(1'b1, 6'h02, 32'hFF, 64'h0000_0001_0000_0009, 6'h20);
        check("R9 mask clear index 255", 64'(rd_data), 64'h19);

        // R1: reset mid-run restores defaults
        @(negedge clk);
        wr_en = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        read_now(6'h10);
        check("R1 pending word0 after reset", 64'(rd_data), 64'h9);
        check("R1 req after second reset", req, 64'h0);
        read_now(6'h20);
        check("R1 mask word0 after second reset", 64'(rd_data), 64'h0);
        read_now(6'h00);
        check("R2 size word after reset", 64'(rd_data), 64'h7);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule